// File: doc/BRIEF.md
# DMA Channel Security Fault Checker

This block sits beside the instruction decoder of a multi-channel DMA engine and polices the instructions of each channel thread that touch peripherals or the channel-control register. A decoded instruction arrives with its class, the channel that issued it, the addressed peripheral and, for a control-register move, whether it asks for a secure bus transfer. A channel thread that runs in the non-secure state may only talk to peripherals that were configured as non-secure, and may never ask for secure transfers. A breach turns the instruction into a no-op, records the fault, and moves the channel into a faulting sequence.

A permitted instruction goes ahead. A wait parks the channel until the peripheral's request arrives. A load or store arms an acknowledgement that is sent when the data transfer finishes. A flush clears the stored request of the peripheral and asks it to resend its level status. Each peripheral's security bit is captured from a configuration vector while reset is held. Fault records stay set until a per-channel kill clears them.

Top module: `dma_sec_guard`

## Requirements
- R1: While and after reset every channel state reads 0 (executing), and `fault_src`, both per-channel error vectors, `req_pending`, `periph_ack`, `flush_resend`, `op_nop` and `ccr_write_en` all read 0.
- R2: An accepted wait (class 0), load (1), store (2) or flush (3) from a non-secure thread to a peripheral whose captured bit is 0 pulses `op_nop` in the next cycle. It also sets the channel's bits in `fault_src` and `periph_err`, moves the channel to state 2 (faulting-completing), and has no acknowledgement or flush effect.
- R3: An accepted control-register move (class 4) from a non-secure thread with `ccr_secure` = 1 pulses `op_nop` in the next cycle and never `ccr_write_en`. It also sets the channel's bits in `fault_src` and `rdwr_err` and moves the channel to state 2.
- R4: A permitted control-register move pulses `ccr_write_en` for one cycle in the next cycle, and the channel stays in state 0.
- R5: A permitted wait moves the channel to state 1 (waiting). The channel stays there until that peripheral's bit in `req_pending` is set. In the following cycle the channel returns to state 0 and the pending bit is cleared.
- R6: A permitted load or store arms an acknowledgement. The cycle after `xfer_done` is high for that channel, `periph_ack` carries a single one-cycle pulse on the peripheral's bit.
- R7: A permitted flush clears that peripheral's `req_pending` bit and pulses its `flush_resend` bit in the next cycle.
- R8: When a request and a flush for the same peripheral arrive in one cycle, the flush wins. The pending bit ends 0, and a channel waiting on that peripheral stays in state 1.
- R9: A thread marked secure (`ch_nonsecure` bit 0) is never faulted. Its instructions behave as permitted whatever the peripheral's bit or `ccr_secure` is.
- R10: A channel in state 2 moves to state 3 (faulted) when its `drain_done` bit is high. Fault records are sticky until a kill.
- R11: A kill of a channel clears its `fault_src`, `periph_err` and `rdwr_err` bits and returns it to state 0 in the next cycle.
- R12: Peripheral security bits are captured from `periph_ns_cfg` only while `rst_n` is low. Later changes of that input have no effect.
- R13: An instruction issued to a channel that is not in state 0 is ignored: no `op_nop`, no `ccr_write_en`, no change of records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_ns_cfg | input | NUM_PERIPH | Per-peripheral security bits (1 = non-secure), captured in reset |
| ch_nonsecure | input | NUM_CH | Security state of each channel thread (1 = non-secure) |
| issue_valid | input | 1 | Decoded instruction present |
| issue_ch | input | CH_W | Issuing channel |
| issue_kind | input | 3 | Instruction class: 0 wait, 1 load, 2 store, 3 flush, 4 control move |
| issue_periph | input | PERIPH_W | Addressed peripheral |
| ccr_secure | input | 1 | Control move requests a secure transfer |
| periph_req | input | NUM_PERIPH | Peripheral request pulses |
| xfer_done | input | NUM_CH | Data transfer of a channel finished |
| drain_done | input | NUM_CH | Outstanding transfers of a channel drained |
| kill_valid | input | 1 | Kill/clear request |
| kill_ch | input | CH_W | Channel to kill |
| ch_state | output | 2*NUM_CH | Channel states, 2 bits per channel, channel c at bits 2c+1:2c |
| fault_src | output | NUM_CH | Per-channel fault flag |
| periph_err | output | NUM_CH | Peripheral-error fault type per channel |
| rdwr_err | output | NUM_CH | Read/write-error fault type per channel |
| req_pending | output | NUM_PERIPH | Stored peripheral requests |
| periph_ack | output | NUM_PERIPH | Completion acknowledgement pulses |
| flush_resend | output | NUM_PERIPH | Resend-level-status pulses |
| op_nop | output | 1 | Previous accepted instruction ran as a no-op |
| ccr_write_en | output | 1 | Permitted control-register write strobe |

## Verification
The bench aims at the same-cycle race of a request against a flush. A design that let the request survive, or that let the waiting channel consume it, would leave `req_pending` set or release the channel early. It checks that secure threads pass secure peripherals and secure control moves, which a design that ignored the thread's state would turn into no-ops. It also changes the configuration vector after reset, issues to channels that are busy or faulted, and lets the drain arrive only after several cycles. A design that re-sampled the configuration, accepted issues in any state or dropped sticky records would show the wrong state or flags at the ports.

// File: rtl/dsg_pkg.sv
// Shared encodings of the DMA channel security fault checker.
// Assumes: instruction classes and channel states are fixed encodings seen at the ports.
package dsg_pkg;
    typedef enum logic [2:0] {
        OP_WAIT  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_FLUSH = 3'd3,
        OP_CTRL  = 3'd4
    } op_kind_t;

    typedef enum logic [1:0] {
        CH_EXEC    = 2'd0,
        CH_WAIT    = 2'd1,
        CH_FCOMP   = 2'd2,
        CH_FAULTED = 2'd3
    } ch_state_t;
endpackage

// File: rtl/dsg_policy.sv
// Security decision for one decoded instruction.
// Assumes: purely combinational; the caller qualifies with issue acceptance.
module dsg_policy
    import dsg_pkg::*;
(
    input  op_kind_t kind,
    input  logic     thread_ns,
    input  logic     periph_ns_bit,
    input  logic     ccr_secure,
    output logic     fault_periph,
    output logic     fault_rdwr,
    output logic     permit
);
    logic is_periph_op;

    // Classify the instruction and test it against the security settings.
    always_comb begin
        is_periph_op = (kind == OP_WAIT) || (kind == OP_LOAD) ||
                       (kind == OP_STORE) || (kind == OP_FLUSH);
        fault_periph = thread_ns && is_periph_op && !periph_ns_bit;
        fault_rdwr   = thread_ns && (kind == OP_CTRL) && ccr_secure;
        permit       = !(fault_periph || fault_rdwr);
    end
endmodule

// File: rtl/dsg_req_track.sv
// Stored peripheral request flags with flush and consume handling.
// Assumes: a flush in the same cycle as a request or a consume overrides both.
module dsg_req_track #(
    parameter int NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] req_in,
    input  logic [NUM_PERIPH-1:0] flush_vec,
    input  logic [NUM_PERIPH-1:0] consume_vec,
    output logic [NUM_PERIPH-1:0] pend_q,
    output logic [NUM_PERIPH-1:0] avail
);
    // Requests visible to waiting channels exclude those being flushed now.
    always_comb avail = pend_q & ~flush_vec;

    // Collect new requests, drop consumed ones, flush clears everything for its peripheral.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~consume_vec) | req_in) & ~flush_vec;
    end
endmodule

// File: rtl/dsg_channel.sv
// State, fault-type record and pending acknowledgement of one DMA channel.
// Assumes: go is high only when the channel is executing and not being killed.
module dsg_channel
    import dsg_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    localparam int PERIPH_W  = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  op_kind_t              kind,
    input  logic [PERIPH_W-1:0]   periph,
    input  logic                  fault_periph,
    input  logic                  fault_rdwr,
    input  logic [NUM_PERIPH-1:0] avail,
    input  logic                  xfer_done,
    input  logic                  drain_done,
    input  logic                  kill,
    output ch_state_t             state_q,
    output logic                  periph_err_q,
    output logic                  rdwr_err_q,
    output logic [NUM_PERIPH-1:0] consume,
    output logic                  ack_valid_q,
    output logic [PERIPH_W-1:0]   ack_periph_q
);
    logic [PERIPH_W-1:0] wait_p_q;
    logic                ack_armed_q;
    logic                req_seen;

    // A waiting channel sees its peripheral's request when it is stored and not flushed.
    always_comb begin
        req_seen = (state_q == CH_WAIT) && avail[wait_p_q] && !kill;
        consume  = '0;
        if (req_seen) consume[wait_p_q] = 1'b1;
    end

    // Channel sequencing, fault recording and acknowledgement arming.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            state_q      <= CH_EXEC;
            periph_err_q <= 1'b0;
            rdwr_err_q   <= 1'b0;
            wait_p_q     <= '0;
            ack_armed_q  <= 1'b0;
            ack_valid_q  <= 1'b0;
            ack_periph_q <= '0;
        end else begin
            ack_valid_q <= ack_armed_q && xfer_done;
            if (ack_armed_q && xfer_done) ack_armed_q <= 1'b0;
            unique case (state_q)
                CH_EXEC: if (go) begin
                    if (fault_periph || fault_rdwr) begin
                        state_q      <= CH_FCOMP;
                        periph_err_q <= periph_err_q | fault_periph;
                        rdwr_err_q   <= rdwr_err_q | fault_rdwr;
                    end else if (kind == OP_WAIT) begin
                        state_q  <= CH_WAIT;
                        wait_p_q <= periph;
                    end else if (kind == OP_LOAD || kind == OP_STORE) begin
                        ack_armed_q  <= 1'b1;
                        ack_periph_q <= periph;
                    end
                end
                CH_WAIT:    if (req_seen) state_q <= CH_EXEC;
                CH_FCOMP:   if (drain_done) state_q <= CH_FAULTED;
                CH_FAULTED: state_q <= CH_FAULTED;
                default:    state_q <= CH_EXEC;
            endcase
        end
    end
endmodule

// File: rtl/dma_sec_guard.sv
// Top of the DMA channel security fault checker: accepts one decoded instruction
// per cycle, applies the security policy, and keeps per-channel fault records.
// Assumes: peripheral security bits are fixed after reset; one issue per cycle.
module dma_sec_guard
    import dsg_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_PERIPH = 8,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int PERIPH_W  = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_ns_cfg,
    input  logic [NUM_CH-1:0]     ch_nonsecure,
    input  logic                  issue_valid,
    input  logic [CH_W-1:0]       issue_ch,
    input  logic [2:0]            issue_kind,
    input  logic [PERIPH_W-1:0]   issue_periph,
    input  logic                  ccr_secure,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic [NUM_CH-1:0]     xfer_done,
    input  logic [NUM_CH-1:0]     drain_done,
    input  logic                  kill_valid,
    input  logic [CH_W-1:0]       kill_ch,
    output logic [2*NUM_CH-1:0]   ch_state,
    output logic [NUM_CH-1:0]     fault_src,
    output logic [NUM_CH-1:0]     periph_err,
    output logic [NUM_CH-1:0]     rdwr_err,
    output logic [NUM_PERIPH-1:0] req_pending,
    output logic [NUM_PERIPH-1:0] periph_ack,
    output logic [NUM_PERIPH-1:0] flush_resend,
    output logic                  op_nop,
    output logic                  ccr_write_en
);
    op_kind_t                              kind;
    logic [NUM_PERIPH-1:0]                 ns_q;
    logic                                  thread_ns;
    logic                                  fault_periph, fault_rdwr, permit;
    logic                                  accepted, fault_any;
    logic [NUM_PERIPH-1:0]                 flush_vec, avail, consume_all;
    ch_state_t                             st   [NUM_CH];
    logic [NUM_CH-1:0][NUM_PERIPH-1:0]     consume_arr;
    logic [NUM_CH-1:0]                     ack_v;
    logic [NUM_CH-1:0][PERIPH_W-1:0]       ack_p;

    assign kind      = op_kind_t'(issue_kind);
    assign thread_ns = ch_nonsecure[issue_ch];

    // Capture peripheral security bits only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ns_q <= periph_ns_cfg;
    end

    dsg_policy i_policy (
        .kind          (kind),
        .thread_ns     (thread_ns),
        .periph_ns_bit (ns_q[issue_periph]),
        .ccr_secure    (ccr_secure),
        .fault_periph  (fault_periph),
        .fault_rdwr    (fault_rdwr),
        .permit        (permit)
    );

    // Accept an issue only for an executing channel that is not being killed.
    always_comb begin
        accepted  = issue_valid && (st[issue_ch] == CH_EXEC) &&
                    !(kill_valid && (kill_ch == issue_ch));
        fault_any = accepted && !permit;
        flush_vec = '0;
        if (accepted && permit && kind == OP_FLUSH) flush_vec[issue_periph] = 1'b1;
    end

    dsg_req_track #(.NUM_PERIPH(NUM_PERIPH)) i_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_in      (periph_req),
        .flush_vec   (flush_vec),
        .consume_vec (consume_all),
        .pend_q      (req_pending),
        .avail       (avail)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dsg_channel #(.NUM_PERIPH(NUM_PERIPH)) i_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .go           (accepted && (issue_ch == CH_W'(c))),
            .kind         (kind),
            .periph       (issue_periph),
            .fault_periph (fault_periph),
            .fault_rdwr   (fault_rdwr),
            .avail        (avail),
            .xfer_done    (xfer_done[c]),
            .drain_done   (drain_done[c]),
            .kill         (kill_valid && (kill_ch == CH_W'(c))),
            .state_q      (st[c]),
            .periph_err_q (periph_err[c]),
            .rdwr_err_q   (rdwr_err[c]),
            .consume      (consume_arr[c]),
            .ack_valid_q  (ack_v[c]),
            .ack_periph_q (ack_p[c])
        );
        assign ch_state[2*c +: 2] = st[c];
    end

    // Merge per-channel consumes and acknowledgements into peripheral vectors.
    always_comb begin
        consume_all = '0;
        periph_ack  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            consume_all = consume_all | consume_arr[c];
            if (ack_v[c]) periph_ack[ack_p[c]] = 1'b1;
        end
    end

    // Shared fault-source record and one-cycle result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_src    <= '0;
            op_nop       <= 1'b0;
            ccr_write_en <= 1'b0;
            flush_resend <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (kill_valid && kill_ch == CH_W'(c))        fault_src[c] <= 1'b0;
                else if (fault_any && issue_ch == CH_W'(c))   fault_src[c] <= 1'b1;
            end
            op_nop       <= fault_any;
            ccr_write_en <= accepted && permit && (kind == OP_CTRL);
            flush_resend <= flush_vec;
        end
    end
endmodule

// File: rtl/dma_sec_guard_chk.sv
// Property checker for dma_sec_guard, bound to every instance of the top.
// Assumes: observes ports and the top's internal decision signals only.
module dma_sec_guard_chk #(
    parameter int NUM_CH     = 4,
    parameter int NUM_PERIPH = 8,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  accepted,
    input logic                  fault_any,
    input logic                  fault_rdwr,
    input logic                  permit,
    input logic                  thread_ns,
    input logic [2:0]            issue_kind,
    input logic [NUM_PERIPH-1:0] flush_vec,
    input logic [NUM_PERIPH-1:0] req_pending,
    input logic [NUM_PERIPH-1:0] flush_resend,
    input logic                  op_nop,
    input logic                  ccr_write_en,
    input logic                  kill_valid,
    input logic [CH_W-1:0]       kill_ch,
    input logic [NUM_CH-1:0]     fault_src
);
    assert_nop_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> op_nop);

    assert_no_write_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && fault_rdwr) |=> !ccr_write_en);

    assert_write_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && permit && issue_kind == 3'd4) |=> (ccr_write_en && !op_nop));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_vec) |=> (((req_pending & $past(flush_vec)) == '0) &&
                          (flush_resend == $past(flush_vec))));

    assert_secure_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !thread_ns) |=> !op_nop);

    assert_sticky_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_any && !kill_valid) |=> (fault_src == $past(fault_src)));

    assert_kill_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |=> !fault_src[$past(kill_ch)]);
endmodule

bind dma_sec_guard dma_sec_guard_chk #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accepted     (accepted),
    .fault_any    (fault_any),
    .fault_rdwr   (fault_rdwr),
    .permit       (permit),
    .thread_ns    (thread_ns),
    .issue_kind   (issue_kind),
    .flush_vec    (flush_vec),
    .req_pending  (req_pending),
    .flush_resend (flush_resend),
    .op_nop       (op_nop),
    .ccr_write_en (ccr_write_en),
    .kill_valid   (kill_valid),
    .kill_ch      (kill_ch),
    .fault_src    (fault_src)
);

// File: tb/test_dma_sec_guard.sv
// Self-checking bench: a vector table walked on channel 1, then directed cases.
module test_dma_sec_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NP  = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] periph_ns_cfg;
    logic [NCH-1:0] ch_nonsecure;
    logic          issue_valid;
    logic [1:0]    issue_ch;
    logic [2:0]    issue_kind;
    logic [2:0]    issue_periph;
    logic          ccr_secure;
    logic [NP-1:0] periph_req;
    logic [NCH-1:0] xfer_done, drain_done;
    logic          kill_valid;
    logic [1:0]    kill_ch;
    logic [2*NCH-1:0] ch_state;
    logic [NCH-1:0] fault_src, periph_err, rdwr_err;
    logic [NP-1:0] req_pending, periph_ack, flush_resend;
    logic          op_nop, ccr_write_en;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_sec_guard #(.NUM_CH(NCH), .NUM_PERIPH(NP)) i_dma_sec_guard (.*);

    // Row fields: {thread_ns, kind[2:0], periph[2:0], ccr_sec, exp_nop, exp_we, exp_state[1:0]}
    localparam logic [11:0] VEC [10] = '{
        {1'b1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 2'd2},  // R2 wait, secure periph
        {1'b1, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 2'd1},  // R5 wait, non-secure periph
        {1'b1, 3'd1, 3'd2, 1'b0, 1'b1, 1'b0, 2'd2},  // R2 load, secure periph
        {1'b1, 3'd2, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0},  // R12 store, bit captured in reset
        {1'b1, 3'd3, 3'd4, 1'b0, 1'b1, 1'b0, 2'd2},  // R2 flush, secure periph
        {1'b1, 3'd4, 3'd0, 1'b1, 1'b1, 1'b0, 2'd2},  // R3 secure control move
        {1'b1, 3'd4, 3'd0, 1'b0, 1'b0, 1'b1, 2'd0},  // R4 plain control move
        {1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0},  // R9 secure thread load
        {1'b0, 3'd4, 3'd0, 1'b1, 1'b0, 1'b1, 2'd0},  // R9 secure thread control move
        {1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1}   // R9 secure thread wait
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int ch, input logic [2:0] k, input int p, input logic sec);
        issue_valid  = 1'b1;
        issue_ch     = 2'(ch);
        issue_kind   = k;
        issue_periph = 3'(p);
        ccr_secure   = sec;
        tick();
        issue_valid  = 1'b0;
    endtask

    task automatic kill(input int ch);
        kill_valid = 1'b1;
        kill_ch    = 2'(ch);
        tick();
        kill_valid = 1'b0;
    endtask

    function automatic logic [1:0] stof(input int ch);
        return ch_state[2*ch +: 2];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; periph_ns_cfg = 8'hAA; ch_nonsecure = '1;
        issue_valid = 0; issue_ch = 0; issue_kind = 0; issue_periph = 0; ccr_secure = 0;
        periph_req = 0; xfer_done = 0; drain_done = 0; kill_valid = 0; kill_ch = 0;
        tick(); tick();
        chk("R1 states", 32'(ch_state), 0);
        chk("R1 records", 32'({fault_src, periph_err, rdwr_err}), 0);
        chk("R1 strobes", 32'({req_pending, periph_ack, flush_resend, op_nop, ccr_write_en}), 0);
        rst_n = 1'b1;
        periph_ns_cfg = 8'h00;   // R12: must not be re-sampled
        tick();

        for (int i = 0; i < 10; i++) begin
            logic [11:0] v = VEC[i];
            logic nop_e = v[3];
            logic ctrl = (v[10:8] == 3'd4);
            ch_nonsecure[1] = v[11];
            issue(1, v[10:8], int'(v[7:5]), v[4]);
            chk($sformatf("R2/R3/R4/R9 row%0d op_nop", i), 32'(op_nop), 32'(nop_e));
            chk($sformatf("R4 row%0d ccr_write_en", i), 32'(ccr_write_en), 32'(v[2]));
            chk($sformatf("R2/R5 row%0d state", i), 32'(stof(1)), 32'(v[1:0]));
            chk($sformatf("R2/R3 row%0d records", i),
                32'({fault_src[1], periph_err[1], rdwr_err[1]}),
                32'({nop_e, nop_e && !ctrl, nop_e && ctrl}));
            kill(1);
            chk($sformatf("R11 row%0d cleared", i),
                32'({stof(1), fault_src[1], periph_err[1], rdwr_err[1]}), 0);
        end
        ch_nonsecure = '1;

        // R5: wait releases only after the request is stored
        issue(0, 3'd0, 1, 1'b0);
        tick();
        chk("R5 still waiting", 32'(stof(0)), 1);
        periph_req = 8'h02; tick(); periph_req = 0;
        chk("R5 request stored", 32'({stof(0), req_pending}), 32'({2'd1, 8'h02}));
        tick();
        chk("R5 released and consumed", 32'({stof(0), req_pending}), 0);

        // R8: flush from channel 1 races a request on peripheral 3
        issue(0, 3'd0, 3, 1'b0);
        periph_req = 8'h08;
        issue(1, 3'd3, 3, 1'b0);
        periph_req = 0;
        chk("R8 pending cleared", 32'(req_pending), 0);
        chk("R7 resend pulse", 32'(flush_resend), 32'h08);
        chk("R8 channel still waiting", 32'(stof(0)), 1);
        tick();
        chk("R7 resend one cycle", 32'(flush_resend), 0);
        chk("R8 waiting after flush", 32'(stof(0)), 1);
        periph_req = 8'h08; tick(); periph_req = 0; tick();
        chk("R5 later request releases", 32'(stof(0)), 0);

        // R6: acknowledgement after transfer completion
        issue(2, 3'd1, 5, 1'b0);
        chk("R6 no early ack", 32'(periph_ack), 0);
        xfer_done = 4'b0100; tick(); xfer_done = 0;
        chk("R6 ack pulse", 32'(periph_ack), 32'h20);
        tick();
        chk("R6 ack one cycle", 32'(periph_ack), 0);

        // R10: faulting-completing waits for drain
        issue(3, 3'd1, 0, 1'b0);
        tick(); tick();
        chk("R10 holds completing", 32'(stof(3)), 2);
        drain_done = 4'b1000; tick(); drain_done = 0;
        chk("R10 faulted", 32'(stof(3)), 3);
        chk("R10 sticky records", 32'({fault_src[3], periph_err[3]}), 32'b11);

        // R13: issue to a faulted channel is ignored
        issue(3, 3'd4, 0, 1'b0);
        chk("R13 no strobe", 32'({op_nop, ccr_write_en}), 0);
        chk("R13 state kept", 32'(stof(3)), 3);
        kill(3);
        chk("R11 kill clears", 32'({stof(3), fault_src[3], periph_err[3]}), 0);

        // R12: peripheral 7 still non-secure despite cfg now zero
        issue(3, 3'd2, 7, 1'b0);
        chk("R12 captured bit used", 32'({op_nop, fault_src[3]}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule